// File: doc/BRIEF.md
# Power-good status and reset generator

This block decides whether a multi-rail board supply is healthy and drives two active-low, open-drain style status lines from that decision. Each rail contributes a power-bad flag from an analog comparator (asynchronous to the block clock) and a gate-enable state that says whether the rail's pass switch is commanded on. The block pulls the healthy line low once every rail that counts is good and every switch is on. It releases the line only after a monitored rail has stayed bad for a programmable deglitch window, which is 15 µs at the intended clock. A switch turning off releases the line at once.

The local reset line is held low while the board is not healthy and also whenever the incoming system reset is low, so downstream logic sees a single reset. A two-bit configuration select can drop the negative rail (the highest-numbered rail) from the decision for boards that do not fit that supply. A sticky bit per rail records which monitored rails were bad when a deglitch window ran out. The bits stay set until a fault-clear pulse arrives. The block reset models the internal supply-low condition and clears all status.

Both outputs are pull-enables: a 1 means the pad driver pulls the line low. The bits `healthy_pull` and `rst_pull` are the same as "healthy_n low" and "local_rst_n low". All pins are plain level control and status. No data stream crosses the block edge.

Top module: `pg_health_rst`

## Requirements
- R1: In steady state `healthy_pull` is 1 exactly when every bit of `gate_on` is 1 and no monitored rail has its `pbad_raw` bit set.
- R2: Each `pbad_raw` bit passes through a two-flop synchronizer. While `healthy_pull` is 1, a monitored bad flag set before clock edge e1 and held causes `healthy_pull` to fall at edge e(DEGLITCH_CYCLES+2). A bad flag held for only DEGLITCH_CYCLES-1 edges has no effect.
- R3: The deglitch count restarts whenever the synchronized flags show all monitored rails good for one cycle. Two bad bursts of DEGLITCH_CYCLES-1 edges each, separated by one good edge, leave `healthy_pull` at 1.
- R4: If any `gate_on` bit is 0 at a clock edge, `healthy_pull` is 0 after that edge, with no deglitch.
- R5: When all gates are on and the last monitored bad flag clears before edge e1, `healthy_pull` rises at edge e3 (synchronizer latency plus one register).
- R6: With `cfg_sel` = 2'b00 all rails are monitored. With 2'b01, 2'b10 or 2'b11, rail NUM_RAILS-1 (the negative rail) is excluded, and its power-bad flag affects neither `healthy_pull` nor `pbad_sticky`.
- R7: `rst_pull` is 1 whenever `healthy_pull` is 0 or `sys_rst_n` is 0, and 0 otherwise. There is no clock delay from `sys_rst_n`.
- R8: At a deglitch expiry, `pbad_sticky[i]` is set for every monitored rail i that is bad at that edge. A one-cycle `fault_clr` pulse clears all sticky bits. A set and a clear on the same edge leave the bit set.
- R9: While `rst_n` is 0, `healthy_pull` and all `pbad_sticky` bits are 0 and `rst_pull` is 1. After release, the synchronizers start from the "bad" state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset (internal supply low) |
| pbad_raw | input | NUM_RAILS | Per-rail power-bad flags from the comparators, asynchronous |
| gate_on | input | NUM_RAILS | Per-rail pass switch commanded-on state |
| cfg_sel | input | 2 | Supply configuration: 00 monitors all rails, other codes drop the negative rail |
| sys_rst_n | input | 1 | Incoming active-low system reset |
| fault_clr | input | 1 | One-cycle pulse that clears the sticky bits |
| healthy_pull | output | 1 | 1 = pull the healthy line low (board healthy) |
| rst_pull | output | 1 | 1 = pull the local reset line low |
| pbad_sticky | output | NUM_RAILS | Per-rail record of deglitched power-bad events |

## Verification
The bench sweeps every combination of gate states, power-bad flags and configuration codes on a four-rail instance with a short deglitch window. This sweep separates the gate term from the rail term and shows that only the negative rail's flag is masked, and only under the non-zero codes. The system reset is toggled in each state so that the reset merge can be checked apart from the health decision. Directed bursts one edge shorter than the window, back-to-back bursts split by one good edge, and a held fault tell correct deglitching apart from an off-by-one count, a counter that does not restart, and one that never expires. A gate drop checks the immediate release path, and a fault clear plus a reset in mid-fault check the sticky record.

// File: rtl/pg_pkg.sv
package pg_pkg;

  // Supply configuration codes on cfg_sel
  typedef enum logic [1:0] {
    CFG_ALL_RAILS = 2'b00,
    CFG_NO_NEG    = 2'b01,
    CFG_ALT_LOW   = 2'b10,
    CFG_RESERVED  = 2'b11
  } pg_cfg_e;

  // True when the negative rail takes part in the health decision
  function automatic logic neg_rail_monitored(input logic [1:0] sel);
    return pg_cfg_e'(sel) == CFG_ALL_RAILS;
  endfunction

endpackage

// File: rtl/pg_sync.sv
// Multi-bit flop chain synchronizer; every bit resets to RST_VAL.
module pg_sync #(
  parameter int   WIDTH   = 4,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {(STAGES*WIDTH){RST_VAL}};
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pg_deglitch.sv
// Counts consecutive cycles of a bad condition; expires on the Nth one.
module pg_deglitch #(
  parameter int DEGLITCH_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bad,
  output logic expired
);

  localparam int CW = (DEGLITCH_CYCLES < 2) ? 1 : $clog2(DEGLITCH_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(DEGLITCH_CYCLES - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!bad) begin
      run_q <= '0;
    end else if (run_q != LAST) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign expired = bad && (run_q == LAST);

endmodule

// File: rtl/pg_sticky.sv
// Per-rail sticky record of rails found bad when a deglitch window ran out.
module pg_sticky #(
  parameter int NUM_RAILS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic [NUM_RAILS-1:0] bad_rails,
  input  logic                 clear,
  output logic [NUM_RAILS-1:0] sticky
);

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (capture && bad_rails[r]) begin
        flag_q <= 1'b1;
      end else if (clear) begin
        flag_q <= 1'b0;
      end
    end
    assign sticky[r] = flag_q;
  end

endmodule

// File: rtl/pg_health_rst.sv
module pg_health_rst #(
  parameter int NUM_RAILS       = 4,
  parameter int DEGLITCH_CYCLES = 3000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RAILS-1:0] pbad_raw,
  input  logic [NUM_RAILS-1:0] gate_on,
  input  logic [1:0]           cfg_sel,
  input  logic                 sys_rst_n,
  input  logic                 fault_clr,
  output logic                 healthy_pull,
  output logic                 rst_pull,
  output logic [NUM_RAILS-1:0] pbad_sticky
);
  import pg_pkg::*;

  localparam int NEG_RAIL = NUM_RAILS - 1;

  logic [NUM_RAILS-1:0] pbad_sync;
  logic [NUM_RAILS-1:0] rail_mask;
  logic [NUM_RAILS-1:0] bad_monitored;
  logic                 any_bad;
  logic                 all_gates_on;
  logic                 dg_expired;
  logic                 healthy_q;

  pg_sync #(
    .WIDTH   (NUM_RAILS),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pbad_raw),
    .q     (pbad_sync)
  );

  // Which rails take part in the decision
  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_mask
    if (r == NEG_RAIL) begin : g_neg
      assign rail_mask[r] = neg_rail_monitored(cfg_sel);
    end else begin : g_pos
      assign rail_mask[r] = 1'b1;
    end
  end

  assign bad_monitored = pbad_sync & rail_mask;
  assign any_bad       = |bad_monitored;
  assign all_gates_on  = &gate_on;

  pg_deglitch #(
    .DEGLITCH_CYCLES (DEGLITCH_CYCLES)
  ) u_deglitch (
    .clk     (clk),
    .rst_n   (rst_n),
    .bad     (any_bad),
    .expired (dg_expired)
  );

  // Asymmetric health state: fast assert, deglitched release on rail faults,
  // immediate release on a switch turning off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      healthy_q <= 1'b0;
    end else if (!all_gates_on || dg_expired) begin
      healthy_q <= 1'b0;
    end else if (!any_bad) begin
      healthy_q <= 1'b1;
    end
  end

  pg_sticky #(
    .NUM_RAILS (NUM_RAILS)
  ) u_sticky (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (dg_expired),
    .bad_rails (bad_monitored),
    .clear     (fault_clr),
    .sticky    (pbad_sticky)
  );

  assign healthy_pull = healthy_q;
  assign rst_pull     = !healthy_q || !sys_rst_n;

endmodule

// File: rtl/pg_health_rst_chk.sv
module pg_health_rst_chk #(
  parameter int NUM_RAILS       = 4,
  parameter int DEGLITCH_CYCLES = 3000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_RAILS-1:0] gate_on,
  input logic                 any_bad,
  input logic                 sys_rst_n,
  input logic                 healthy_pull,
  input logic                 rst_pull,
  input logic [NUM_RAILS-1:0] pbad_sticky
);

  localparam int RW = $clog2(DEGLITCH_CYCLES + 1) + 1;

  // Independent run-length of the monitored bad condition
  logic [RW-1:0] bad_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_run <= '0;
    end else if (!any_bad) begin
      bad_run <= '0;
    end else if (bad_run < RW'(DEGLITCH_CYCLES)) begin
      bad_run <= bad_run + 1'b1;
    end
  end

  // R1
  healthy_needs_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    healthy_pull |-> $past(&gate_on));

  // R2
  release_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(healthy_pull) && $past(&gate_on)) |-> (bad_run >= RW'(DEGLITCH_CYCLES)));

  // R4
  gate_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&gate_on) |=> !healthy_pull);

  // R7
  sys_reset_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> rst_pull);

  // R7
  unhealthy_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !healthy_pull |-> rst_pull);

  // R8
  sticky_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pbad_sticky & ~$past(pbad_sticky)) != '0) |-> !healthy_pull);

endmodule

bind pg_health_rst pg_health_rst_chk #(
  .NUM_RAILS       (NUM_RAILS),
  .DEGLITCH_CYCLES (DEGLITCH_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .gate_on      (gate_on),
  .any_bad      (any_bad),
  .sys_rst_n    (sys_rst_n),
  .healthy_pull (healthy_pull),
  .rst_pull     (rst_pull),
  .pbad_sticky  (pbad_sticky)
);

// File: tb/pg_health_rst_bench.sv
`timescale 1ns/1ps
module pg_health_rst_bench;

  localparam int NR = 4;
  localparam int DG = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] pbad_raw = '0;
  logic [NR-1:0] gate_on = '1;
  logic [1:0]    cfg_sel = 2'b00;
  logic          sys_rst_n = 1'b1;
  logic          fault_clr = 1'b0;
  logic          healthy_pull;
  logic          rst_pull;
  logic [NR-1:0] pbad_sticky;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pg_health_rst #(
    .NUM_RAILS       (NR),
    .DEGLITCH_CYCLES (DG),
    .SYNC_STAGES     (2)
  ) u_pg_health_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .pbad_raw     (pbad_raw),
    .gate_on      (gate_on),
    .cfg_sel      (cfg_sel),
    .sys_rst_n    (sys_rst_n),
    .fault_clr    (fault_clr),
    .healthy_pull (healthy_pull),
    .rst_pull     (rst_pull),
    .pbad_sticky  (pbad_sticky)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [NR-1:0] mask;
    logic          exp_h;

    // R9: state while reset is held
    repeat (2) @(negedge clk);
    chk("R9 healthy in reset", {31'b0, healthy_pull}, 32'd0);
    chk("R9 rst_pull in reset", {31'b0, rst_pull}, 32'd1);
    chk("R9 sticky in reset", {28'b0, pbad_sticky}, 32'd0);
    rst_n = 1'b1;
    // R5: healthy rises at third edge after release (sync starts bad)
    repeat (2) @(negedge clk);
    chk("R5 not yet healthy", {31'b0, healthy_pull}, 32'd0);
    @(negedge clk);
    chk("R5 healthy at e3", {31'b0, healthy_pull}, 32'd1);

    // R1 R6 R7: exhaustive static sweep
    for (int c = 0; c < 4; c++) begin
      for (int g = 0; g < 16; g++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          cfg_sel  = c[1:0];
          gate_on  = g[NR-1:0];
          pbad_raw = b[NR-1:0];
          repeat (DG + 4) @(negedge clk);
          mask  = (c == 0) ? 4'hF : 4'h7;
          exp_h = (g == 15) && ((b[NR-1:0] & mask) == 0);
          chk("R1/R6 healthy sweep", {31'b0, healthy_pull}, {31'b0, exp_h});
          chk("R7 rst_pull sys high", {31'b0, rst_pull}, {31'b0, !exp_h});
          sys_rst_n = 1'b0;
          #1;
          chk("R7 rst_pull sys low", {31'b0, rst_pull}, 32'd1);
          sys_rst_n = 1'b1;
        end
      end
    end

    // Directed tests from a clean, healthy state
    pbad_raw = '0;
    gate_on  = '1;
    cfg_sel  = 2'b00;
    do_reset();
    repeat (4) @(negedge clk);
    chk("R5 healthy before directed", {31'b0, healthy_pull}, 32'd1);

    // R2: burst one edge short of the window is ignored
    pbad_raw[0] = 1'b1;
    repeat (DG - 1) @(negedge clk);
    pbad_raw[0] = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R2 short burst ignored", {31'b0, healthy_pull}, 32'd1);
    end

    // R3: two short bursts split by one good edge
    pbad_raw[2] = 1'b1;
    repeat (DG - 1) @(negedge clk);
    pbad_raw[2] = 1'b0;
    @(negedge clk);
    pbad_raw[2] = 1'b1;
    repeat (DG - 1) @(negedge clk);
    pbad_raw[2] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 restart keeps healthy", {31'b0, healthy_pull}, 32'd1);
    chk("R3 no sticky", {28'b0, pbad_sticky}, 32'd0);

    // R2: held fault releases at edge DG+2
    pbad_raw[1] = 1'b1;
    repeat (DG + 1) @(negedge clk);
    chk("R2 still healthy at DG+1", {31'b0, healthy_pull}, 32'd1);
    @(negedge clk);
    chk("R2 released at DG+2", {31'b0, healthy_pull}, 32'd0);
    chk("R8 sticky set rail1", {28'b0, pbad_sticky}, 32'h2);
    chk("R7 reset follows release", {31'b0, rst_pull}, 32'd1);

    // R5: recovery
    pbad_raw[1] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 recovery not yet", {31'b0, healthy_pull}, 32'd0);
    @(negedge clk);
    chk("R5 recovery at e3", {31'b0, healthy_pull}, 32'd1);
    chk("R8 sticky held", {28'b0, pbad_sticky}, 32'h2);

    // R8: fault clear
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    chk("R8 sticky cleared", {28'b0, pbad_sticky}, 32'h0);

    // R6: negative rail excluded under non-zero code
    cfg_sel = 2'b10;
    pbad_raw[3] = 1'b1;
    repeat (DG + 4) @(negedge clk);
    chk("R6 neg rail ignored healthy", {31'b0, healthy_pull}, 32'd1);
    chk("R6 neg rail ignored sticky", {28'b0, pbad_sticky}, 32'h0);
    cfg_sel = 2'b00;
    repeat (DG + 4) @(negedge clk);
    chk("R6 neg rail monitored", {31'b0, healthy_pull}, 32'd0);
    chk("R8 sticky neg rail", {28'b0, pbad_sticky}, 32'h8);
    pbad_raw[3] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 healthy again", {31'b0, healthy_pull}, 32'd1);

    // R4: gate off releases after one edge
    gate_on[2] = 1'b0;
    @(negedge clk);
    chk("R4 gate off immediate", {31'b0, healthy_pull}, 32'd0);
    chk("R4 sticky untouched", {28'b0, pbad_sticky}, 32'h8);
    gate_on[2] = 1'b1;
    repeat (2) @(negedge clk);

    // R9: reset clears sticky and health
    rst_n = 1'b0;
    #1;
    chk("R9 async clear sticky", {28'b0, pbad_sticky}, 32'h0);
    chk("R9 async clear healthy", {31'b0, healthy_pull}, 32'd0);
    chk("R9 reset pulls local reset", {31'b0, rst_pull}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    finish_run();
  end

endmodule